// File: doc/BRIEF.md
# Ramped Attenuation Control

This block applies a per-channel digital attenuation to six audio sample streams. Each channel has an 8-bit target register. The code is counted in half-decibel steps: 0 means unity gain and 181 means 90.5 dB of attenuation. Every code above 181 silences the channel. The level actually applied does not jump to a newly written target. On each ramp tick it moves one step toward the target, so gain changes are gradual in both directions. The ramp tick is derived from the sample-frame strobe and comes every 1, 2, 4 or 8 frames, as chosen by a two-bit rate input.

Software, or a neighbouring register decoder, writes the targets through a simple write port. An upstream source presents one frame of six samples per `smp_valid` pulse. The scaled samples leave through a two-stage pipeline. The gain is built from a 12-entry fractional mantissa, which covers the steps inside one 6 dB octave, and an arithmetic shift, which covers whole octaves. The result is rounded toward zero. The level currently applied to each channel is exported so that a controller can tell when a fade has finished.

Top module: `atten_ramp_top`

## Requirements
- R1: A write with `reg_we` high updates the target of channel i (0-based) only when `reg_addr` equals 0x07+i, so channels 0 to 5 sit at 0x07 to 0x0C. Writes to any other address change no target.
- R2: While `rst` is high at a clock edge, every target and every current level becomes 0, `out_valid` becomes 0 and every `smp_out` lane becomes 0.
- R3: Frames are counted from reset, and the k-th `smp_valid` pulse is a ramp tick when k is a multiple of N. N is 1, 2, 4 or 8 for `rate_sel` values 0, 1, 2 and 3.
- R4: On a ramp tick, a channel's current level moves by exactly one toward its target and holds once it equals the target. Without a tick the level holds. The step uses the target held before any write in the same cycle.
- R5: A level stepped at a clock edge is visible on `cur_level` immediately after that edge.
- R6: For a current level c from 0 to 181, the output equals s*M[c mod 12] / 2^(15 + c div 12), rounded toward zero. Here s is the signed input sample and M is {32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396}, indexed from 0.
- R7: For a current level from 182 to 255, the output lane is 0.
- R8: `out_valid` rises exactly two clock edges after the edge that samples `smp_valid`. The lanes update only then and otherwise hold their last value. Each frame is scaled with the levels held before that frame's own ramp step.
- R9: At level 0 the output sample equals the input sample exactly, including -32768 and 32767.
- R10: A target of 0xFF makes the current level ramp all the way to 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Target register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Target attenuation code to write |
| rate_sel | input | 2 | Ramp tick divider select: every 1, 2, 4 or 8 frames |
| smp_valid | input | 1 | One frame of samples is present |
| smp_in | input | 6x16 | Signed input samples, lane i is channel i |
| smp_out | output | 6x16 | Signed scaled samples |
| out_valid | output | 1 | The scaled frame on smp_out is new this cycle |
| cur_level | output | 6x8 | Attenuation code currently applied per channel |

## Verification
A register write changes the target at the edge that samples it. That new target takes effect from the next ramp tick onward. A level step appears on `cur_level` right after its tick edge, and a scaled frame appears two edges after its `smp_valid` edge. The bench advances a behavioural model at every rising edge, in the order output stage, input capture, ramp step, register write. It compares every output against the model at the following falling edge, so each result is sampled in the first cycle it is due and in every cycle it must hold.

// File: rtl/atten_pkg.sv
package atten_pkg;

  localparam int FRAC_BITS  = 15;
  localparam int MANT_W     = FRAC_BITS + 1;
  localparam int STEPS_OCT  = 12;

  // Q15 gain for each half-dB step inside one 6 dB octave
  function automatic logic [MANT_W-1:0] frac_gain(input logic [3:0] idx);
    logic [MANT_W-1:0] g;
    case (idx)
      4'd0:    g = 16'd32768;
      4'd1:    g = 16'd30935;
      4'd2:    g = 16'd29205;
      4'd3:    g = 16'd27571;
      4'd4:    g = 16'd26029;
      4'd5:    g = 16'd24573;
      4'd6:    g = 16'd23198;
      4'd7:    g = 16'd21900;
      4'd8:    g = 16'd20675;
      4'd9:    g = 16'd19519;
      4'd10:   g = 16'd18427;
      4'd11:   g = 16'd17396;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/atten_regs.sv
module atten_regs #(
  parameter int NCH  = 6,
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int BASE = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [NCH-1:0][DW-1:0]  tgt
);

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(BASE + i);
    always_ff @(posedge clk) begin
      if (rst)                          tgt[i] <= '0;
      else if (we && addr == MY_ADDR)   tgt[i] <= wdata;
    end
  end

  logic in_range;
  assign in_range = (int'(addr) >= BASE) && (int'(addr) < BASE + NCH);

  // R1: writes outside the target window leave every target untouched
  p_ignore_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (we && !in_range) |=> $stable(tgt));

endmodule

// File: rtl/ramp_tick_gen.sv
module ramp_tick_gen #(
  parameter int RSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame,
  input  logic [RSW-1:0] rate,
  output logic           tick
);

  localparam int CW = (1 << RSW) - 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;
  logic [CW:0]   one_sh;

  always_comb begin
    one_sh = (CW+1)'(1) << rate;
    mask   = CW'(one_sh - (CW+1)'(1));
  end

  assign tick = frame && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (frame) cnt <= cnt + CW'(1);
  end

  // R3: the fastest rate ticks on every frame
  p_rate_fast_r3: assert property (@(posedge clk) disable iff (rst)
    (frame && rate == '0) |-> tick);

  // R3: no tick without a frame strobe
  p_tick_on_frame_r3: assert property (@(posedge clk) disable iff (rst)
    !frame |-> !tick);

endmodule

// File: rtl/level_ramp.sv
module level_ramp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] tgt,
  output logic [DW-1:0] cur
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (tick) begin
      if (cur < tgt)      cur <= cur + DW'(1);
      else if (cur > tgt) cur <= cur - DW'(1);
    end
  end

  // R4: any change of level is a single step
  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cur != $past(cur)) |-> ((cur == $past(cur) + DW'(1)) || (cur == $past(cur) - DW'(1))));

  // R4: no tick, or already at target, means the level holds
  p_hold_level_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick || cur == tgt) |=> $stable(cur));

  // R4: a tick away from target moves toward it
  p_toward_target_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && cur < tgt) |=> (cur == $past(cur) + DW'(1)));

endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import atten_pkg::*;
#(
  parameter int SW       = 16,
  parameter int DW       = 8,
  parameter int MAX_CODE = 181
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] sample,
  input  logic [DW-1:0] level,
  output logic [SW-1:0] out
);

  localparam int OW  = $clog2(((1 << DW) / STEPS_OCT) + 1);
  localparam int SHW = $clog2(FRAC_BITS + (1 << OW) + 1);
  localparam int PW  = SW + MANT_W + 1;

  // stage 1: split the code into octave shift and fractional mantissa
  logic              s1_vld;
  logic [SW-1:0]     s1_smp;
  logic [MANT_W-1:0] s1_mant;
  logic [OW-1:0]     s1_oct;
  logic              s1_zero;

  logic [3:0]        frac_idx;
  logic [OW-1:0]     oct_idx;

  always_comb begin
    frac_idx = 4'(level % DW'(STEPS_OCT));
    oct_idx  = OW'(level / DW'(STEPS_OCT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_smp  <= '0;
      s1_mant <= '0;
      s1_oct  <= '0;
      s1_zero <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_smp  <= sample;
        s1_mant <= frac_gain(frac_idx);
        s1_oct  <= oct_idx;
        s1_zero <= (int'(level) > MAX_CODE);
      end
    end
  end

  // stage 2: multiply, then shift with rounding toward zero
  logic signed [PW-1:0] smp_ext;
  logic signed [PW-1:0] mant_ext;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] bias;
  logic signed [PW-1:0] shifted;
  logic [SHW-1:0]       sh;

  always_comb begin
    smp_ext  = PW'($signed(s1_smp));
    mant_ext = PW'({1'b0, s1_mant});
    prod     = smp_ext * mant_ext;
    sh       = SHW'(FRAC_BITS) + SHW'(s1_oct);
    bias     = prod[PW-1] ? ((PW'(1) << sh) - PW'(1)) : '0;
    shifted  = (prod + bias) >>> sh;
  end

  always_ff @(posedge clk) begin
    if (rst)         out <= '0;
    else if (s1_vld) out <= s1_zero ? '0 : shifted[SW-1:0];
  end

  // R7: a level beyond the table range silences the lane
  p_full_mute_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(level) > MAX_CODE) |=> ##1 (out == '0));

  // R9: level zero passes the sample through unchanged
  p_unity_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && level == '0) |=> ##1 (out == $past(sample, 2)));

  // R6: attenuation never increases magnitude
  p_no_gain_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !$signed(sample[SW-1])) |=> ##1 ($signed(out) <= $signed($past(sample, 2))));

endmodule

// File: rtl/atten_ramp_top.sv
module atten_ramp_top #(
  parameter int NCH       = 6,
  parameter int SW        = 16,
  parameter int DW        = 8,
  parameter int AW        = 8,
  parameter int RSW       = 2,
  parameter int BASE_ADDR = 7,
  parameter int MAX_CODE  = 181
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [AW-1:0]           reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  input  logic [RSW-1:0]          rate_sel,
  input  logic                    smp_valid,
  input  logic [NCH-1:0][SW-1:0]  smp_in,
  output logic [NCH-1:0][SW-1:0]  smp_out,
  output logic                    out_valid,
  output logic [NCH-1:0][DW-1:0]  cur_level
);

  logic [NCH-1:0][DW-1:0] tgt;
  logic                   tick;
  logic                   vld_d1;

  atten_regs #(
    .NCH(NCH), .AW(AW), .DW(DW), .BASE(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .tgt(tgt)
  );

  ramp_tick_gen #(.RSW(RSW)) u_tick (
    .clk(clk), .rst(rst), .frame(smp_valid), .rate(rate_sel), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    level_ramp #(.DW(DW)) u_ramp (
      .clk(clk), .rst(rst), .tick(tick), .tgt(tgt[c]), .cur(cur_level[c])
    );

    gain_scaler #(.SW(SW), .DW(DW), .MAX_CODE(MAX_CODE)) u_scale (
      .clk(clk), .rst(rst), .in_valid(smp_valid), .sample(smp_in[c]),
      .level(cur_level[c]), .out(smp_out[c])
    );
  end

  // valid tracks the two scaler pipeline stages
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_d1    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      vld_d1    <= smp_valid;
      out_valid <= vld_d1;
    end
  end

  // R8: every frame produces a valid output two edges later
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ##1 out_valid);

  // R8: no valid output without a frame two edges earlier
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_valid, 2));

  // R8: lanes hold between valid outputs
  p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(vld_d1) |-> $stable(smp_out));

endmodule

// File: tb/tb_atten_ramp_top.sv
module tb_atten_ramp_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   reg_we = 1'b0;
  logic [7:0]             reg_addr = '0;
  logic [7:0]             reg_wdata = '0;
  logic [1:0]             rate_sel = '0;
  logic                   smp_valid = 1'b0;
  logic [NCH-1:0][15:0]   smp_in = '0;
  logic [NCH-1:0][15:0]   smp_out;
  logic                   out_valid;
  logic [NCH-1:0][7:0]    cur_level;

  atten_ramp_top dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rate_sel(rate_sel), .smp_valid(smp_valid),
    .smp_in(smp_in), .smp_out(smp_out), .out_valid(out_valid),
    .cur_level(cur_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_en  = 0;
  bit done    = 0;

  // reference model state
  int  MANT[12] = '{32768, 30935, 29205, 27571, 26029, 24573,
                    23198, 21900, 20675, 19519, 18427, 17396};
  int  m_tgt[NCH];
  int  m_cur[NCH];
  int  m_frames;
  bit  m_v1, m_v2;
  int  m_s1_smp[NCH];
  int  m_s1_code[NCH];
  int  m_out[NCH];
  int  m_out_code[NCH];

  function automatic int scale(int s, int c);
    longint p;
    int     sh;
    if (c > 181) return 0;
    p  = longint'(s) * longint'(MANT[c % 12]);
    sh = 15 + c / 12;
    if (p < 0) return -int'((-p) >> sh);
    return int'(p >> sh);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_tgt[c] = 0; m_cur[c] = 0; m_out[c] = 0; m_out_code[c] = 0;
      end
      m_frames = 0; m_v1 = 0; m_v2 = 0;
    end else begin
      if (m_v1)
        for (int c = 0; c < NCH; c++) begin
          m_out[c]      = scale(m_s1_smp[c], m_s1_code[c]);
          m_out_code[c] = m_s1_code[c];
        end
      m_v2 = m_v1;
      m_v1 = smp_valid;
      if (smp_valid) begin
        for (int c = 0; c < NCH; c++) begin
          m_s1_smp[c]  = int'($signed(smp_in[c]));
          m_s1_code[c] = m_cur[c];
        end
        m_frames++;
        if (m_frames % (1 << rate_sel) == 0)
          for (int c = 0; c < NCH; c++) begin
            if (m_cur[c] < m_tgt[c])      m_cur[c]++;
            else if (m_cur[c] > m_tgt[c]) m_cur[c]--;
          end
      end
      if (reg_we && reg_addr >= 8'h07 && reg_addr <= 8'h0C)
        m_tgt[reg_addr - 8'h07] = int'(reg_wdata);
    end
  end

  always @(negedge clk) begin
    if (chk_en && !rst && !done) begin
      check("R8 valid", int'(out_valid), int'(m_v2));
      for (int c = 0; c < NCH; c++) begin
        check("R1 R3 R4 R5 level", int'(cur_level[c]), m_cur[c]);
        if (!m_v2)                   check("R8 hold", int'($signed(smp_out[c])), m_out[c]);
        else if (m_out_code[c] > 181) check("R7 mute", int'($signed(smp_out[c])), m_out[c]);
        else if (m_out_code[c] == 0) check("R9 unity", int'($signed(smp_out[c])), m_out[c]);
        else                         check("R6 scale", int'($signed(smp_out[c])), m_out[c]);
      end
    end
  end

  task automatic step(bit v, bit we, logic [7:0] a, logic [7:0] d);
    smp_valid = v;
    reg_we    = we;
    reg_addr  = a;
    reg_wdata = d;
    for (int c = 0; c < NCH; c++) begin
      case ($urandom % 8)
        0:       smp_in[c] = 16'h8000;
        1:       smp_in[c] = 16'h7FFF;
        default: smp_in[c] = 16'($urandom);
      endcase
    end
    @(negedge clk);
  endtask

  task automatic frames(int n, int gap_every);
    for (int i = 0; i < n; i++)
      step((gap_every == 0) || (i % gap_every != 0), 1'b0, 8'h00, 8'h00);
  endtask

  task automatic reset_check();
    for (int c = 0; c < NCH; c++) begin
      check("R2 reset level", int'(cur_level[c]), 0);
      check("R2 reset out", int'(smp_out[c]), 0);
    end
    check("R2 reset valid", int'(out_valid), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst = 1'b0;
    chk_en = 1;

    // R9: all levels at 0, unity pass-through
    rate_sel = 2'd0;
    frames(20, 0);

    // R1: targets at 0x07..0x0C, neighbours ignored
    step(1'b0, 1'b1, 8'h07, 8'd12);
    step(1'b1, 1'b1, 8'h08, 8'd13);
    step(1'b0, 1'b1, 8'h09, 8'd181);
    step(1'b1, 1'b1, 8'h0A, 8'hFF);
    step(1'b0, 1'b1, 8'h0B, 8'd5);
    step(1'b1, 1'b1, 8'h06, 8'd99);
    step(1'b1, 1'b1, 8'h0D, 8'd77);
    step(1'b0, 1'b1, 8'h0C, 8'd0);

    // R4 R6 R7: ramp up at full rate with gaps
    frames(400, 3);
    check("R10 ramp to full", int'(cur_level[3]), 255);
    check("R4 reach target", int'(cur_level[2]), 181);
    check("R1 ch6 untouched", int'(cur_level[5]), 0);

    // R3: slower rates, ramp down and reversal
    rate_sel = 2'd1;
    step(1'b0, 1'b1, 8'h0A, 8'd170);
    step(1'b0, 1'b1, 8'h07, 8'd0);
    frames(120, 0);
    rate_sel = 2'd2;
    step(1'b0, 1'b1, 8'h09, 8'd100);
    frames(60, 4);
    step(1'b1, 1'b1, 8'h09, 8'd200);
    frames(150, 0);
    rate_sel = 2'd3;
    step(1'b0, 1'b1, 8'h0C, 8'd30);
    frames(250, 5);
    rate_sel = 2'd0;
    frames(60, 0);

    // R2: reset from a busy state
    chk_en = 0;
    rst = 1'b1;
    step(1'b1, 1'b0, 8'h00, 8'h00);
    step(1'b0, 1'b0, 8'h00, 8'h00);
    reset_check();
    finish_run();
  end

endmodule